// File: doc/BRIEF.md
# I/O Access Trap SMI Generator

This block turns decoded I/O accesses into a system management interrupt so that power management software can bring a device back from standby. Address comparators sit outside the block. For each monitored device they deliver a hit strobe, which is sampled together with a cycle-start pulse. A trap is taken only when the global trap enable is set and the hit device's own trap enable is also set. When a trap is taken, the block records status for the device and for the block as a whole, and it raises SMI.

The interrupt is tied to the completion of the I/O instruction that caused it. The block drives a ready-permit signal to the cycle controller, and the controller may return ready to the CPU only while that signal is high. On a trapped cycle the permit stays low until SMI has been high for a set lead time, three host clocks by default. This makes sure the CPU sees SMI before the instruction retires. Cycles that are not trapped get the permit at once. SMI stays high until software clears every per-device status bit by writing ones to them.

Top module: `io_trap_smi`

## Requirements
- R1: While the global enable (register 0, bit 0) is 0, no cycle sets any status bit or raises SMI, whatever the hits and device enables are.
- R2: A hit on a device whose enable bit (register 1, bit i for device i) is 0 sets no status and raises no SMI, including when it is hit in the same cycle as an enabled device.
- R3: A trapped cycle sets, on the next clock, the per-device status bit (register 2, bit i; also the trap_dev_o port) of every enabled device hit in that cycle.
- R4: A trapped cycle sets the summary status bit (register 3, bit 0; also trap_sum_o) on the next clock. Writing 1 to register 3 bit 0 clears it, and clearing it does not affect SMI.
- R5: SMI rises on the clock after a trapped cycle and stays high until all per-device status bits are 0.
- R6: In a trapped cycle rdy_ok_o goes low in that same cycle. It returns high in the fourth cycle after it (LEAD=3), so SMI is high for at least LEAD cycles before the permit.
- R7: In a cycle that is not trapped, with no lead sequence running, rdy_ok_o is high in that same cycle.
- R8: When several enabled devices are hit in one cycle, all of their status bits are set and only one lead sequence runs, with the same timing as a single hit.
- R9: Writing 1 to register 2 bit i clears status bit i. Bits written 0 keep their value. A trap on device i in the same cycle as the clear leaves the bit set.
- R10: After reset all enables and status bits are 0, SMI is 0 and rdy_ok_o is 1. Reads return register 0 bit 0, register 1 bits [NDEV-1:0], register 2 bits [NDEV-1:0] and register 3 bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start_i | input | 1 | One-cycle pulse that marks the start of an I/O cycle |
| dev_hit_i | input | NDEV | Per-device range hit strobes, valid with cyc_start_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select, used for reads and writes |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data for the selected register |
| smi_o | output | 1 | System management interrupt request |
| rdy_ok_o | output | 1 | Permit for the cycle controller to return ready |
| trap_sum_o | output | 1 | Summary trap status |
| trap_dev_o | output | NDEV | Per-device trap status |

## Verification
The assertions check on every cycle that the ready-permit never rises while a trap is waiting unless SMI has been high for the lead time. They also check that a trapped cycle sets its status and SMI on the next clock, that a disabled global enable never changes status, and that SMI cannot drop without a write to the status register. Only the bench scenarios show the exact cycle in which the permit returns, that status bits written with zero survive, that the summary clear leaves SMI alone, and how a clear and a trap on the same bit in one cycle resolve.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

    // Register selects
    typedef enum logic [1:0] {
        RA_GEN_EN   = 2'd0,
        RA_DEV_EN   = 2'd1,
        RA_DEV_STAT = 2'd2,
        RA_SUM_STAT = 2'd3
    } reg_addr_e;

    // Lead sequencer state
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_HOLD = 1'b1
    } lead_st_e;

    // Outcome of qualifying one cycle
    typedef struct packed {
        logic fire;    // at least one enabled device hit
        logic quiet;   // cycle start with no trap
    } trap_evt_t;

    function automatic int lead_cnt_w(input int lead);
        return (lead < 1) ? 1 : $clog2(lead + 1);
    endfunction

endpackage

// File: rtl/io_trap_qual.sv
module io_trap_qual
    import io_trap_pkg::*;
#(
    parameter int NDEV = 6
) (
    input  logic            cyc_start,
    input  logic            gen_en,
    input  logic [NDEV-1:0] dev_en,
    input  logic [NDEV-1:0] hit,
    output logic [NDEV-1:0] qual_hit,
    output trap_evt_t       evt
);

    // One gate per monitored device
    for (genvar gi = 0; gi < NDEV; gi++) begin : g_dev
        assign qual_hit[gi] = cyc_start & gen_en & dev_en[gi] & hit[gi];
    end

    always_comb begin
        evt.fire  = |qual_hit;
        evt.quiet = cyc_start & ~(|qual_hit);
    end

endmodule

// File: rtl/io_trap_lead.sv
module io_trap_lead
    import io_trap_pkg::*;
#(
    parameter int LEAD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic hold
);

    localparam int CW = lead_cnt_w(LEAD);

    lead_st_e       st_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LD_IDLE;
            cnt_q <= '0;
        end else if (fire) begin
            // (re)start one sequence, however many devices hit
            st_q  <= LD_HOLD;
            cnt_q <= CW'(LEAD);
        end else if (st_q == LD_HOLD) begin
            if (cnt_q <= CW'(1)) begin
                st_q  <= LD_IDLE;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign hold = (st_q == LD_HOLD);

endmodule

// File: rtl/io_trap_regs.sv
module io_trap_regs
    import io_trap_pkg::*;
#(
    parameter int NDEV = 6,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NDEV-1:0] qual_hit,
    input  trap_evt_t       evt,
    output logic            gen_en,
    output logic [NDEV-1:0] dev_en,
    output logic [NDEV-1:0] dev_stat,
    output logic            sum_stat,
    output logic            smi,
    output logic [DW-1:0]   rdata
);

    reg_addr_e      sel;
    logic [NDEV-1:0] dev_clr;
    logic            sum_clr;
    logic [NDEV-1:0] dev_stat_d;

    assign sel     = reg_addr_e'(addr);
    assign dev_clr = (wr && sel == RA_DEV_STAT) ? wdata[NDEV-1:0] : '0;
    assign sum_clr = wr && sel == RA_SUM_STAT && wdata[0];

    // new trap wins over a clear in the same cycle
    assign dev_stat_d = (dev_stat & ~dev_clr) | qual_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en   <= 1'b0;
            dev_en   <= '0;
            dev_stat <= '0;
            sum_stat <= 1'b0;
            smi      <= 1'b0;
        end else begin
            if (wr && sel == RA_GEN_EN) gen_en <= wdata[0];
            if (wr && sel == RA_DEV_EN) dev_en <= wdata[NDEV-1:0];
            dev_stat <= dev_stat_d;
            if (evt.fire)     sum_stat <= 1'b1;
            else if (sum_clr) sum_stat <= 1'b0;
            smi <= |dev_stat_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            RA_GEN_EN:   rdata[0]        = gen_en;
            RA_DEV_EN:   rdata[NDEV-1:0] = dev_en;
            RA_DEV_STAT: rdata[NDEV-1:0] = dev_stat;
            RA_SUM_STAT: rdata[0]        = sum_stat;
        endcase
    end

endmodule

// File: rtl/io_trap_smi.sv
module io_trap_smi
    import io_trap_pkg::*;
#(
    parameter int NDEV = 6,
    parameter int DW   = 16,
    parameter int LEAD = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_start_i,
    input  logic [NDEV-1:0] dev_hit_i,
    input  logic            reg_wr_i,
    input  logic [1:0]      reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            smi_o,
    output logic            rdy_ok_o,
    output logic            trap_sum_o,
    output logic [NDEV-1:0] trap_dev_o
);

    logic            gen_en;
    logic [NDEV-1:0] dev_en;
    logic [NDEV-1:0] qual_hit;
    trap_evt_t       evt;
    logic            hold;

    io_trap_qual #(.NDEV(NDEV)) u_qual (
        .cyc_start (cyc_start_i),
        .gen_en    (gen_en),
        .dev_en    (dev_en),
        .hit       (dev_hit_i),
        .qual_hit  (qual_hit),
        .evt       (evt)
    );

    io_trap_lead #(.LEAD(LEAD)) u_lead (
        .clk  (clk),
        .rst  (rst),
        .fire (evt.fire),
        .hold (hold)
    );

    io_trap_regs #(.NDEV(NDEV), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .qual_hit (qual_hit),
        .evt      (evt),
        .gen_en   (gen_en),
        .dev_en   (dev_en),
        .dev_stat (trap_dev_o),
        .sum_stat (trap_sum_o),
        .smi      (smi_o),
        .rdata    (reg_rdata_o)
    );

    // permit withheld in the trap cycle itself and during the lead window
    assign rdy_ok_o = ~evt.fire & ~hold;

endmodule

// File: rtl/io_trap_smi_chk.sv
module io_trap_smi_chk #(
    parameter int NDEV = 6,
    parameter int DW   = 16,
    parameter int LEAD = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            cyc_start_i,
    input logic [NDEV-1:0] dev_hit_i,
    input logic            reg_wr_i,
    input logic [1:0]      reg_addr_i,
    input logic            smi_o,
    input logic            rdy_ok_o,
    input logic            trap_sum_o,
    input logic [NDEV-1:0] trap_dev_o,
    input logic            gen_en,
    input logic [NDEV-1:0] dev_en
);

    logic [NDEV-1:0] en_hit;
    logic            trap_now;
    logic            stat_wr;
    logic            waiting;
    logic [7:0]      smi_run;

    assign en_hit   = dev_hit_i & dev_en;
    assign trap_now = cyc_start_i && gen_en && (|en_hit);
    assign stat_wr  = reg_wr_i && reg_addr_i == 2'd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
            smi_run <= '0;
        end else begin
            if (trap_now)      waiting <= 1'b1;
            else if (rdy_ok_o) waiting <= 1'b0;
            if (!smi_o)                 smi_run <= '0;
            else if (smi_run < 8'(LEAD)) smi_run <= smi_run + 8'd1;
        end
    end

    assert_lead_time_R6: assert property (@(posedge clk) disable iff (rst)
        (waiting && rdy_ok_o) |-> (smi_run >= 8'(LEAD)));

    assert_trap_blocks_ready_R6: assert property (@(posedge clk) disable iff (rst)
        trap_now |-> !rdy_ok_o);

    assert_fast_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_i && !trap_now && !waiting) |-> rdy_ok_o);

    assert_gate_off_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_i && !gen_en && !stat_wr) |=> (trap_dev_o == $past(trap_dev_o)));

    assert_dev_stat_set_R3: assert property (@(posedge clk) disable iff (rst)
        trap_now |=> ((trap_dev_o & $past(en_hit)) == $past(en_hit)));

    assert_sum_set_R4: assert property (@(posedge clk) disable iff (rst)
        trap_now |=> trap_sum_o);

    assert_smi_rise_R5: assert property (@(posedge clk) disable iff (rst)
        trap_now |=> smi_o);

    assert_smi_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (smi_o && !stat_wr) |=> smi_o);

endmodule

bind io_trap_smi io_trap_smi_chk #(.NDEV(NDEV), .DW(DW), .LEAD(LEAD)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cyc_start_i (cyc_start_i),
    .dev_hit_i   (dev_hit_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .smi_o       (smi_o),
    .rdy_ok_o    (rdy_ok_o),
    .trap_sum_o  (trap_sum_o),
    .trap_dev_o  (trap_dev_o),
    .gen_en      (gen_en),
    .dev_en      (dev_en)
);

// File: tb/tb_io_trap_smi.sv
module tb_io_trap_smi;

    localparam int NDEV = 6;
    localparam int DW   = 16;
    localparam int LEAD = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            cyc_start_i;
    logic [NDEV-1:0] dev_hit_i;
    logic            reg_wr_i;
    logic [1:0]      reg_addr_i;
    logic [DW-1:0]   reg_wdata_i;
    logic [DW-1:0]   reg_rdata_o;
    logic            smi_o;
    logic            rdy_ok_o;
    logic            trap_sum_o;
    logic [NDEV-1:0] trap_dev_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    io_trap_smi #(.NDEV(NDEV), .DW(DW), .LEAD(LEAD)) dut (
        .clk(clk), .rst(rst), .cyc_start_i(cyc_start_i), .dev_hit_i(dev_hit_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .smi_o(smi_o), .rdy_ok_o(rdy_ok_o),
        .trap_sum_o(trap_sum_o), .trap_dev_o(trap_dev_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [DW-1:0] exp);
        reg_addr_i = a;
        #1;
        check(req, 32'(reg_rdata_o), 32'(exp));
    endtask

    // Run one I/O cycle; check permit timing for trapped or plain cycles
    task automatic io_cycle(input string req, input logic [NDEV-1:0] hits, input bit trapped);
        @(negedge clk);
        cyc_start_i = 1'b1; dev_hit_i = hits;
        #1;
        check({req, " permit in start cycle"}, 32'(rdy_ok_o), 32'(!trapped));
        @(negedge clk);                       // cycle t+1
        cyc_start_i = 1'b0; dev_hit_i = '0;
        if (trapped) begin
            #1;
            check({req, " smi t+1"}, 32'(smi_o), 32'd1);
            check({req, " permit low t+1"}, 32'(rdy_ok_o), 32'd0);
            for (int k = 2; k <= LEAD; k++) begin
                @(negedge clk);
                #1;
                check({req, " permit low in lead"}, 32'(rdy_ok_o), 32'd0);
            end
            @(negedge clk);                   // cycle t+LEAD+1
            #1;
            check({req, " permit after lead"}, 32'(rdy_ok_o), 32'd1);
            check({req, " smi during permit"}, 32'(smi_o), 32'd1);
        end
    endtask

    task automatic t_reset;
        check("R10 reset smi", 32'(smi_o), 32'd0);
        check("R10 reset permit", 32'(rdy_ok_o), 32'd1);
        check("R10 reset dev stat", 32'(trap_dev_o), 32'd0);
        check("R10 reset sum", 32'(trap_sum_o), 32'd0);
        rd_check("R10 read gen en", 2'd0, '0);
        rd_check("R10 read dev en", 2'd1, '0);
    endtask

    task automatic t_global_off;
        wr_reg(2'd1, 16'hFFFF);
        rd_check("R10 dev en readback masks width", 2'd1, 16'h003F);
        io_cycle("R1/R7 global off", 6'b000100, 0);
        #1;
        check("R1 no status", 32'(trap_dev_o), 32'd0);
        check("R1 no smi", 32'(smi_o), 32'd0);
        check("R1 no sum", 32'(trap_sum_o), 32'd0);
    endtask

    task automatic t_dev_off;
        wr_reg(2'd1, 16'h0005);
        wr_reg(2'd0, 16'h0001);
        rd_check("R10 gen en readback", 2'd0, 16'h0001);
        io_cycle("R2/R7 disabled device", 6'b000010, 0);
        #1;
        check("R2 no status", 32'(trap_dev_o), 32'd0);
        check("R2 no smi", 32'(smi_o), 32'd0);
    endtask

    task automatic t_single;
        io_cycle("R6 single trap", 6'b000110, 1);
        check("R3 dev stat (R2 disabled bit clear)", 32'(trap_dev_o), 32'h04);
        check("R4 sum set", 32'(trap_sum_o), 32'd1);
        rd_check("R10 dev stat read", 2'd2, 16'h0004);
        rd_check("R10 sum read", 2'd3, 16'h0001);
        io_cycle("R7 plain cycle after lead", 6'b000000, 0);
    endtask

    task automatic t_clear;
        wr_reg(2'd2, 16'h0000);
        #1;
        check("R9 zero write keeps status", 32'(trap_dev_o), 32'h04);
        wr_reg(2'd3, 16'h0001);
        #1;
        check("R4 sum cleared", 32'(trap_sum_o), 32'd0);
        check("R4/R5 smi kept after sum clear", 32'(smi_o), 32'd1);
        wr_reg(2'd2, 16'h0004);
        #1;
        check("R9 status cleared", 32'(trap_dev_o), 32'd0);
        check("R5 smi dropped", 32'(smi_o), 32'd0);
    endtask

    task automatic t_multi;
        wr_reg(2'd1, 16'h003F);
        io_cycle("R8 multi-hit single lead", 6'b100011, 1);
        check("R8 all status set", 32'(trap_dev_o), 32'h23);
        wr_reg(2'd2, 16'h0001);
        #1;
        check("R9 only bit0 cleared", 32'(trap_dev_o), 32'h22);
        check("R5 smi held with bits left", 32'(smi_o), 32'd1);
        wr_reg(2'd2, 16'h0022);
        #1;
        check("R5 smi off after last clear", 32'(smi_o), 32'd0);
    endtask

    task automatic t_race;
        io_cycle("R6 trap before race", 6'b001000, 1);
        @(negedge clk);
        cyc_start_i = 1'b1; dev_hit_i = 6'b001000;
        reg_wr_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'h0008;
        @(negedge clk);
        cyc_start_i = 1'b0; dev_hit_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        #1;
        check("R9 trap wins over clear", 32'(trap_dev_o), 32'h08);
        check("R5 smi stays on race", 32'(smi_o), 32'd1);
        repeat (LEAD + 1) @(negedge clk);
        wr_reg(2'd2, 16'h0008);
        wr_reg(2'd0, 16'h0000);
        io_cycle("R1 global off again", 6'b111111, 0);
        #1;
        check("R1 no status when off", 32'(trap_dev_o), 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cyc_start_i = 1'b0; dev_hit_i = '0;
        reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_global_off();
        t_dev_off();
        t_single();
        t_clear();
        t_multi();
        t_race();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule